// File: doc/BRIEF.md
# Queued SPI Master Sequencer with Wraparound

The block is an SPI master that runs a list of transfers on its own. A small internal queue holds, for each entry, a transmit word, a receive word and a command word; the command word selects which chip-select lines go low for that entry. Once enabled, the sequencer walks the queue from a start pointer to an end pointer. For each entry it runs one transfer of `DW` bits, MSB first, and stores the word it receives. The clock idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge.

In one-shot mode the walk ends at the end pointer: the enable bit clears and the completion flag sets. In wraparound mode the walk reloads the start pointer and repeats until software asks it to leave. There are two graceful ways out. Clearing the wrap enable lets the walk run to the next end of the queue and then stop as in one-shot mode. Setting the halt bit stops the walk after the transfer in progress and keeps the current pointer, so clearing halt resumes from the next entry. Software reaches the queue only through an address register and a data register, and the address increments after every data access.

The register bus is a plain single-cycle strobe bus. A write completes on the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr`. The bus has no back-pressure and no wait states.

Top module: `qspi_queue_top`

## Requirements
- R1: Each queue entry gives one SPI transfer of DW bits, MSB first. SCK idles low, MOSI is stable around each rising edge, and `cs_n` equals the bitwise inverse of the entry's command word (low CS_W bits) for the whole transfer. `cs_n` is all ones between transfers. A walk visits entries in increasing index order from the start pointer to the end pointer.
- R2: In one-shot mode (wrap enable 0), completing the end entry sets the completion flag and clears the enable bit, and no further transfer starts.
- R3: The current pointer steps from index DEPTH-1 to 0, so a walk with end pointer below start pointer crosses the top of the queue. The current pointer reads back in WRAP[23:16].
- R4: In wraparound mode (wrap enable 1), completing the end entry sets the flag, leaves the enable bit at 1 and reloads the start pointer. The walk continues while `irq` is asserted.
- R5: Each completed transfer writes its received word into the receive entry of the same index, overwriting the word from an earlier pass.
- R6: If wrap enable is cleared during wraparound, the walk continues to the next completion of the end entry. It then sets the flag, clears the enable bit and stops.
- R7: Setting halt (WRAP bit 25) lets the transfer in progress finish and then starts no further transfer. The enable bit stays 1 and the current pointer holds the next entry. Clearing halt resumes the walk from that entry.
- R8: The completion flag (IRQ bit 0) is cleared only by writing 1 to IRQ bit 0. Writing 0 there has no effect.
- R9: `irq` is high exactly when the completion flag and the interrupt enable (IRQ bit 8) are both 1.
- R10: The registers are 32-bit at word offsets 0 MODE (divider in bits 7:0), 1 CTRL (enable in bit 0), 2 WRAP (start 3:0, end 11:8, current 23:16, wrap enable 24, halt 25), 3 IRQ, 4 QADDR and 5 QDATA. Offsets 6 and 7 and all other bits read 0, and writes to them are ignored. Writing CTRL bit 0 from 0 to 1 loads the current pointer with the start pointer.
- R11: QDATA accesses the queue word at QADDR and then increments QADDR. QADDR 0 to 15 select transmit words, 16 to 31 receive words and 32 to 47 command words; 48 to 63 read 0. Writes to receive words are ignored.
- R12: After reset all registers read 0, `irq` is 0, `sck` is 0 and `cs_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Completion interrupt request |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | CS_W | Active-low chip selects |

## Verification
The hardest states to reach from the ports are the two exits from wraparound. Each needs a register write that lands inside a particular transfer of a particular pass, while the sequencer keeps running between bus accesses. The bench counts transfer starts and ends at the SPI pins, and it issues the wrap-disable or halt write after a chosen count, so the write falls mid-transfer. The SPI slave model inverts its reply from the second pass onward. A receive word that shows the inverted value therefore proves it was overwritten, and a neighbouring word that still holds the first-pass value shows that the later transfer has not yet completed.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [2:0] {
    OFF_MODE  = 3'd0,
    OFF_CTRL  = 3'd1,
    OFF_WRAP  = 3'd2,
    OFF_IRQ   = 3'd3,
    OFF_QADDR = 3'd4,
    OFF_QDATA = 3'd5
  } reg_off_e;

  localparam logic [1:0] RGN_TX  = 2'd0;
  localparam logic [1:0] RGN_RX  = 2'd1;
  localparam logic [1:0] RGN_CMD = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_BUSY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int DW    = 16,
  parameter int CS_W  = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DW-1:0]    tx_i,
  input  logic [CS_W-1:0]  cs_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             done_o,
  output logic [DW-1:0]    rx_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic [CS_W-1:0]  cs_n_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic             busy_q, sck_q, samp_q, done_q;
  logic [DW-1:0]    sh_q;
  logic [BW-1:0]    bit_q;
  logic [DIV_W-1:0] div_q;
  logic [CS_W-1:0]  cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b0; samp_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '0; bit_q <= '0; div_q <= '0; cs_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sh_q   <= tx_i;
        bit_q  <= '0;
        sck_q  <= 1'b0;
        div_q  <= '0;
        cs_q   <= cs_i;
      end else if (busy_q) begin
        if (div_q == div_i) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q  <= 1'b1;
            samp_q <= miso_i;
          end else begin
            sck_q <= 1'b0;
            sh_q  <= {sh_q[DW-2:0], samp_q};
            if (bit_q == BW'(DW-1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = sh_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[DW-1];
  assign cs_n_o = busy_q ? ~cs_q : '1;

  // R1
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cs_n_o));

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_o);
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spe_i,
  input  logic          halt_i,
  input  logic          wrap_i,
  input  logic          go_i,
  input  logic [AW-1:0] start_ptr_i,
  input  logic [AW-1:0] end_ptr_i,
  input  logic          done_i,
  output logic          xfer_start_o,
  output logic [AW-1:0] cur_o,
  output logic          rx_we_o,
  output logic          end_o,
  output logic          spe_clr_o
);
  seq_state_e    state_q;
  logic [AW-1:0] cur_q;
  logic          fin;

  assign fin          = (state_q == S_BUSY) && done_i;
  assign xfer_start_o = (state_q == S_ISSUE);
  assign rx_we_o      = fin;
  assign end_o        = fin && (cur_q == end_ptr_i);
  assign spe_clr_o    = end_o && !wrap_i;
  assign cur_o        = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (go_i)                  cur_q   <= start_ptr_i;
          else if (spe_i && !halt_i) state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_BUSY;
        S_BUSY: begin
          if (done_i) begin
            state_q <= S_IDLE;
            if (cur_q == end_ptr_i) begin
              if (wrap_i) cur_q <= start_ptr_i;
            end else begin
              cur_q <= cur_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && !wrap_i) |=> !spe_i);

  // R7
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && state_q == S_IDLE) |=> (state_q == S_IDLE));
endmodule

// File: rtl/qspi_regs.sv
module qspi_regs
  import qspi_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CS_W  = 4,
  parameter int AW    = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [AW-1:0]    cur_i,
  input  logic             rx_we_i,
  input  logic [DW-1:0]    rx_i,
  input  logic             end_i,
  input  logic             spe_clr_i,
  output logic             spe_o,
  output logic             halt_o,
  output logic             wrap_o,
  output logic             go_o,
  output logic [AW-1:0]    start_ptr_o,
  output logic [AW-1:0]    end_ptr_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DW-1:0]    tx_o,
  output logic [CS_W-1:0]  cs_o,
  output logic             irq_o
);
  localparam int DEPTH = 1 << AW;
  localparam int RAW   = AW + 2;

  logic [DIV_W-1:0] div_q;
  logic             spe_q, go_q, wrap_q, halt_q, flag_q, ie_q;
  logic [AW-1:0]    sp_q, ep_q;
  logic [RAW-1:0]   qa_q;
  logic [DW-1:0]    tx_mem  [DEPTH];
  logic [DW-1:0]    rx_mem  [DEPTH];
  logic [CS_W-1:0]  cmd_mem [DEPTH];

  logic          wr_en, rd_en, dat_acc, unused_bits;
  logic [1:0]    rgn;
  logic [AW-1:0] idx;

  assign wr_en       = bus_sel && bus_wr;
  assign rd_en       = bus_sel && !bus_wr;
  assign dat_acc     = bus_sel && (bus_addr == OFF_QDATA);
  assign rgn         = qa_q[RAW-1:AW];
  assign idx         = qa_q[AW-1:0];
  assign unused_bits = ^{bus_wdata, rd_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; spe_q <= 1'b0; go_q <= 1'b0; wrap_q <= 1'b0;
      halt_q <= 1'b0; flag_q <= 1'b0; ie_q <= 1'b0;
      sp_q <= '0; ep_q <= '0; qa_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (wr_en) begin
        case (bus_addr)
          OFF_MODE: div_q <= bus_wdata[DIV_W-1:0];
          OFF_CTRL: begin
            spe_q <= bus_wdata[0];
            go_q  <= bus_wdata[0] && !spe_q;
          end
          OFF_WRAP: begin
            sp_q   <= bus_wdata[0 +: AW];
            ep_q   <= bus_wdata[8 +: AW];
            wrap_q <= bus_wdata[24];
            halt_q <= bus_wdata[25];
          end
          OFF_IRQ: begin
            ie_q <= bus_wdata[8];
            if (bus_wdata[0]) flag_q <= 1'b0;
          end
          OFF_QADDR: qa_q <= bus_wdata[RAW-1:0];
          default: ;
        endcase
      end
      if (dat_acc) qa_q <= qa_q + 1'b1;
      if (end_i) flag_q <= 1'b1;
      if (spe_clr_i) spe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && bus_addr == OFF_QDATA) begin
      if (rgn == RGN_TX)  tx_mem[idx]  <= bus_wdata[DW-1:0];
      if (rgn == RGN_CMD) cmd_mem[idx] <= bus_wdata[CS_W-1:0];
    end
    if (rx_we_i) rx_mem[cur_i] <= rx_i;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_MODE: bus_rdata[DIV_W-1:0] = div_q;
      OFF_CTRL: bus_rdata[0] = spe_q;
      OFF_WRAP: begin
        bus_rdata[0 +: AW]  = sp_q;
        bus_rdata[8 +: AW]  = ep_q;
        bus_rdata[16 +: AW] = cur_i;
        bus_rdata[24]       = wrap_q;
        bus_rdata[25]       = halt_q;
      end
      OFF_IRQ: begin
        bus_rdata[0] = flag_q;
        bus_rdata[8] = ie_q;
      end
      OFF_QADDR: bus_rdata[RAW-1:0] = qa_q;
      OFF_QDATA: begin
        case (rgn)
          RGN_TX:  bus_rdata[DW-1:0]   = tx_mem[idx];
          RGN_RX:  bus_rdata[DW-1:0]   = rx_mem[idx];
          RGN_CMD: bus_rdata[CS_W-1:0] = cmd_mem[idx];
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign spe_o       = spe_q;
  assign halt_o      = halt_q;
  assign wrap_o      = wrap_q;
  assign go_o        = go_q;
  assign start_ptr_o = sp_q;
  assign end_ptr_o   = ep_q;
  assign div_o       = div_q;
  assign tx_o        = tx_mem[cur_i];
  assign cs_o        = cmd_mem[cur_i];
  assign irq_o       = flag_q && ie_q;

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_en && bus_addr == OFF_IRQ && bus_wdata[0]));

  // R4
  wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && wrap_q && spe_q && !(wr_en && bus_addr == OFF_CTRL)) |=> spe_q);
endmodule

// File: rtl/qspi_queue_top.sv
module qspi_queue_top #(
  parameter int DW    = 16,
  parameter int CS_W  = 4,
  parameter int AW    = 4,
  parameter int DIV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [CS_W-1:0] cs_n
);
  logic             spe, halt, wrap, go, xfer_start, rx_we, at_end, spe_clr, done;
  logic [AW-1:0]    sp, ep, cur;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    tx, rx;
  logic [CS_W-1:0]  cs_sel;

  qspi_regs #(.DW(DW), .CS_W(CS_W), .AW(AW), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_i(cur), .rx_we_i(rx_we), .rx_i(rx), .end_i(at_end), .spe_clr_i(spe_clr),
    .spe_o(spe), .halt_o(halt), .wrap_o(wrap), .go_o(go),
    .start_ptr_o(sp), .end_ptr_o(ep), .div_o(div), .tx_o(tx), .cs_o(cs_sel),
    .irq_o(irq)
  );

  qspi_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .spe_i(spe), .halt_i(halt), .wrap_i(wrap),
    .go_i(go), .start_ptr_i(sp), .end_ptr_i(ep), .done_i(done),
    .xfer_start_o(xfer_start), .cur_o(cur), .rx_we_o(rx_we),
    .end_o(at_end), .spe_clr_o(spe_clr)
  );

  qspi_shift #(.DW(DW), .CS_W(CS_W), .DIV_W(DIV_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .start_i(xfer_start), .tx_i(tx), .cs_i(cs_sel),
    .div_i(div), .miso_i(miso), .done_o(done), .rx_o(rx), .sck_o(sck),
    .mosi_o(mosi), .cs_n_o(cs_n)
  );
endmodule

// File: tb/qspi_queue_top_tb_top.sv
module qspi_queue_top_tb_top;
  localparam int DW = 16, CS_W = 4, AW = 4, DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sck, mosi, miso;
  logic [CS_W-1:0] cs_n;
  logic invert = 1'b0;

  int vectors = 0, miscompares = 0, xfers = 0, starts = 0, invert_at = -1;
  bit finished = 0;
  logic [CS_W+DW-1:0] exp_q[$];

  always #2 clk = ~clk;
  assign miso = mosi ^ invert;

  qspi_queue_top #(.DW(DW), .CS_W(CS_W), .AW(AW), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  function automatic logic [DW-1:0] tx_val(int i);
    return DW'(32'hA50F ^ (i * 32'h1357));
  endfunction
  function automatic logic [CS_W-1:0] cmd_val(int i);
    return CS_W'((i % 15) + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int i);
    exp_q.push_back({~cmd_val(i), tx_val(i)});
  endtask

  // monitor: rebuilds each SPI transfer from the pins and compares it
  logic in_x = 1'b0, prev_sck = 1'b0;
  logic [DW-1:0] mdata;
  logic [CS_W-1:0] mcs;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_x && cs_n != '1) begin
        in_x = 1'b1; mcs = cs_n; mdata = '0; starts++;
      end else if (in_x) begin
        if (sck && !prev_sck) mdata = {mdata[DW-2:0], mosi};
        if (cs_n == '1) begin
          in_x = 1'b0;
          xfers++;
          if (exp_q.size() == 0) check("R1 unexpected transfer", {12'h0, mcs, mdata}, 32'hFFFFFFFF);
          else check("R1 transfer", {12'h0, mcs, mdata}, {12'h0, exp_q.pop_front()});
          if (xfers == invert_at) invert = 1'b1;
        end
      end
      prev_sck = sck;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_word(input int qa, output logic [31:0] d);
    wr(3'd4, 32'(qa));
    rd(3'd5, d);
  endtask

  task automatic wait_stop();
    logic [31:0] d;
    for (int k = 0; k < 5000; k++) begin
      rd(3'd1, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int b, s;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    rd(3'd0, d); check("R12 MODE", d, 0);
    rd(3'd1, d); check("R12 CTRL", d, 0);
    rd(3'd2, d); check("R12 WRAP", d, 0);
    rd(3'd3, d); check("R12 IRQ", d, 0);
    check("R12 pins", {irq, sck, cs_n}, {2'b00, {CS_W{1'b1}}});

    // R10 reserved bits and unassigned offsets
    wr(3'd0, 32'hFFFFFFFF); rd(3'd0, d); check("R10 MODE reserved", d, 32'h000000FF);
    wr(3'd7, 32'hFFFFFFFF); rd(3'd7, d); check("R10 offset 7", d, 0);
    rd(3'd6, d); check("R10 offset 6", d, 0);
    wr(3'd0, 32'd1);

    // R11 burst fill and readback
    wr(3'd4, 32'd0);
    for (int i = 0; i < 16; i++) wr(3'd5, {16'hDEAD, tx_val(i)});
    rd(3'd4, d); check("R11 auto increment", d, 32'd16);
    wr(3'd4, 32'd32);
    for (int i = 0; i < 16; i++) wr(3'd5, {28'hFFFFFFF, cmd_val(i)});
    rd(3'd4, d); check("R11 auto increment cmd", d, 32'd48);
    wr(3'd4, 32'd0);
    for (int i = 0; i < 16; i++) begin
      rd(3'd5, d); check("R11 tx readback", d, {16'h0, tx_val(i)});
    end
    rd_word(35, d); check("R11 cmd readback", d, {28'h0, cmd_val(3)});
    rd_word(50, d); check("R11 unused region", d, 0);

    // R1 R2 one-shot walk 2..5
    wr(3'd2, 32'h0000_0502);
    for (int i = 2; i <= 5; i++) push(i);
    b = xfers;
    wr(3'd1, 32'd1);
    wait_stop();
    check("R1 oneshot count", 32'(xfers), 32'(b + 4));
    rd(3'd1, d); check("R2 enable cleared", d, 0);
    rd(3'd3, d); check("R2 flag set", d, 32'h1);
    check("R9 irq masked", {31'h0, irq}, 0);
    repeat (200) @(negedge clk);
    check("R2 no further transfer", 32'(xfers), 32'(b + 4));
    for (int i = 2; i <= 5; i++) begin
      rd_word(16 + i, d); check("R5 rx stored", d, {16'h0, tx_val(i)});
    end

    // R8 write-one-to-clear
    wr(3'd3, 32'h0); rd(3'd3, d); check("R8 write 0 keeps flag", d, 32'h1);
    wr(3'd3, 32'h1); rd(3'd3, d); check("R8 write 1 clears flag", d, 32'h0);

    // R3 R4 R5 R6 wraparound 14..1 across the top
    wr(3'd3, 32'h100);
    wr(3'd2, 32'h0100_010E);
    for (int p = 0; p < 2; p++) begin push(14); push(15); push(0); push(1); end
    b = xfers;
    invert_at = b + 4;
    wr(3'd1, 32'd1);
    while (xfers < b + 5) @(negedge clk);
    check("R4 irq while looping", {31'h0, irq}, 32'h1);
    rd(3'd1, d); check("R4 enable kept", d, 32'h1);
    rd(3'd2, d); check("R3 current pointer", (d >> 16) & 32'hF, 32'd15);
    rd_word(16 + 14, d); check("R5 overwritten", d, {16'h0, ~tx_val(14)});
    rd_word(16 + 15, d); check("R5 first pass kept", d, {16'h0, tx_val(15)});
    wr(3'd2, 32'h0000_010E);
    wait_stop();
    check("R6 stops at next end", 32'(xfers), 32'(b + 8));
    rd(3'd3, d); check("R6 flag set", d, 32'h101);
    check("R6 expected drained", 32'(exp_q.size()), 0);
    begin
      int ids[4] = '{14, 15, 0, 1};
      foreach (ids[k]) begin
        rd_word(16 + ids[k], d); check("R5 second pass", d, {16'h0, ~tx_val(ids[k])});
      end
    end
    invert = 1'b0;

    // R9 enable masks the request
    check("R9 irq on", {31'h0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    check("R9 irq off", {31'h0, irq}, 0);
    rd(3'd3, d); check("R8 flag held", d, 32'h1);
    wr(3'd3, 32'h1);

    // R11 rx write ignored
    wr(3'd4, 32'd30); wr(3'd5, 32'h1234);
    rd_word(30, d); check("R11 rx write ignored", d, {16'h0, ~tx_val(14)});

    // R7 halt in wraparound, then resume one-shot
    wr(3'd2, 32'h0100_0700);
    push(0); push(1); push(2);
    b = xfers; s = starts;
    wr(3'd1, 32'd1);
    while (starts < s + 3) @(negedge clk);
    wr(3'd2, 32'h0300_0700);
    while (xfers < b + 3) @(negedge clk);
    repeat (300) @(negedge clk);
    check("R7 halted count", 32'(xfers), 32'(b + 3));
    rd(3'd1, d); check("R7 enable kept", d, 32'h1);
    rd(3'd2, d); check("R7 pointer held", (d >> 16) & 32'hF, 32'd3);
    rd(3'd3, d); check("R7 no flag", d & 32'h1, 0);
    for (int i = 3; i <= 7; i++) push(i);
    wr(3'd2, 32'h0000_0700);
    wait_stop();
    check("R7 resumed count", 32'(xfers), 32'(b + 8));
    rd(3'd3, d); check("R2 flag after resume", d & 32'h1, 32'h1);

    finished = 1;
    summary();
    $finish;
  end
endmodule